// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the word address for a synchronous burst memory. A new burst starts when either of two load strobes is seen at a rising clock edge. One strobe comes from the processor side and one from the controller side, and each strobe has its own address input. While no strobe is present, every clock edge that sees the advance input high steps a small beat counter. The low address bits then follow that counter. The bits above the counter never change inside a burst. Bursting is optional: a fresh address may be loaded on every edge with no idle cycle.

An order select input is sampled together with the strobe that starts a burst. When it is high, the low bits step in linear order, which is the loaded bits plus the beat count with wrap-around. When it is low, or left at its tie-off of zero, the low bits step in interleaved order, which is the loaded bits XOR the beat count. The current beat index is also an output. The width of the counter is a parameter; the default of 2 bits gives four-beat bursts.

Top module: `burst_addr_gen`

## Requirements
- R1: While rst_n is low, word_addr and beat_idx are both zero.
- R2: If cpu_strobe is high at a rising edge, then after that edge word_addr equals cpu_addr and beat_idx is 0.
- R3: If ctl_strobe is high and cpu_strobe is low at a rising edge, then after that edge word_addr equals ctl_addr and beat_idx is 0.
- R4: If both strobes are high at the same edge, cpu_addr is loaded and ctl_addr is ignored.
- R5: At an edge with no strobe and advance high, beat_idx increases by one modulo 2^BEAT_W. With the default of 2 bits, the beat after 3 is 0.
- R6: At an edge with no strobe and advance low, word_addr and beat_idx hold their values.
- R7: advance has no effect at an edge where a strobe loads an address, so beat_idx is 0 after that edge.
- R8: If seq_linear was 1 at the loading edge, the low BEAT_W bits of word_addr equal (loaded low bits + beat_idx) mod 2^BEAT_W.
- R9: If seq_linear was 0 at the loading edge, the low BEAT_W bits of word_addr equal loaded low bits XOR beat_idx.
- R10: Between loads, the bits of word_addr above the low BEAT_W bits keep their loaded value.
- R11: seq_linear is sampled only at a loading edge. Changing it during a burst does not change the order of that burst.
- R12: Strobes on consecutive edges each load their address, with no lost cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_strobe | input | 1 | Processor-side load strobe, higher priority |
| cpu_addr | input | ADDR_W | Address loaded by cpu_strobe |
| ctl_strobe | input | 1 | Controller-side load strobe |
| ctl_addr | input | ADDR_W | Address loaded by ctl_strobe |
| advance | input | 1 | Step the burst by one beat |
| seq_linear | input | 1 | 1 selects linear order, 0 selects interleaved order; sampled at load |
| word_addr | output | ADDR_W | Current word address |
| beat_idx | output | BEAT_W | Beat index within the burst |

## Verification
The assertions check on every cycle the following properties:
- strobe priority and the loaded address;
- that the counter clears on a load and ignores advance there;
- that the counter steps by one or holds;
- that the upper address bits stay steady between loads;
- that beat 0 always maps to the loaded address.

The exact linear and interleaved address sequences are shown only by the bench's sweeps. The same holds for wrap-around after the last beat, for the order latched at the loading edge, and for back-to-back loads. The sweeps cover every starting low value in both orders, and each burst runs past its wrap point.

// File: rtl/burst_pkg.sv
package burst_pkg;

   typedef enum logic {
      ORD_XOR = 1'b0,
      ORD_ADD = 1'b1
   } burst_order_e;

   function automatic burst_order_e order_from_pin(input logic pin);
      return pin ? ORD_ADD : ORD_XOR;
   endfunction

endpackage

// File: rtl/burst_load_sel.sv
module burst_load_sel #(
   parameter int ADDR_W = 20
) (
   input  logic              cpu_stb,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              ctl_stb,
   input  logic [ADDR_W-1:0] ctl_addr,
   output logic              load,
   output logic [ADDR_W-1:0] sel_addr
);

   generate
      if (ADDR_W < 2) begin : g_bad_width
         $error("burst_load_sel: ADDR_W must be at least 2");
      end
   endgenerate

   always_comb begin
      load     = cpu_stb | ctl_stb;
      sel_addr = cpu_stb ? cpu_addr : ctl_addr;
   end

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
   parameter int BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              advance,
   output logic [BEAT_W-1:0] beat
);

   localparam logic [BEAT_W-1:0] ONE = BEAT_W'(1);

   generate
      if (BEAT_W < 1 || BEAT_W > 8) begin : g_bad_beat
         $error("burst_beat_ctr: BEAT_W must be in 1..8");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       beat <= '0;
      else if (load)    beat <= '0;
      else if (advance) beat <= beat + ONE;
   end

   // R7: a load clears the beat whatever advance does
   p_load_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (beat == '0));

   // R5: advance alone steps by one, with wrap-around
   p_step_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && advance) |=> (beat == $past(beat) + ONE));

   // R6: no load and no advance holds the beat
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !advance) |=> $stable(beat));

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
   import burst_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int BEAT_W = 2
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [BEAT_W-1:0] beat,
   input  burst_order_e      order,
   output logic [ADDR_W-1:0] addr
);

   localparam int HI_W = ADDR_W - BEAT_W;

   generate
      if (HI_W < 1) begin : g_bad_split
         $error("burst_order_map: ADDR_W must exceed BEAT_W");
      end
   endgenerate

   logic [BEAT_W-1:0] lo_add;
   logic [BEAT_W-1:0] lo_xor;
   logic [BEAT_W-1:0] lo_sel;

   always_comb begin
      lo_add = base[BEAT_W-1:0] + beat;
      lo_xor = base[BEAT_W-1:0] ^ beat;
      lo_sel = (order == ORD_ADD) ? lo_add : lo_xor;
      addr   = {base[ADDR_W-1:BEAT_W], lo_sel};
   end

   // R8 R9: the first beat of either order is the loaded address
   always_comb begin
      if (beat == '0) begin
         a_first_beat_r8: assert (addr == base);
      end
   end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
   import burst_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_strobe,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              ctl_strobe,
   input  logic [ADDR_W-1:0] ctl_addr,
   input  logic              advance,
   input  logic              seq_linear,
   output logic [ADDR_W-1:0] word_addr,
   output logic [BEAT_W-1:0] beat_idx
);

   localparam int HI_W = ADDR_W - BEAT_W;

   generate
      if (HI_W < 1) begin : g_bad_cfg
         $error("burst_addr_gen: ADDR_W must exceed BEAT_W");
      end
   endgenerate

   logic              load;
   logic [ADDR_W-1:0] sel_addr;
   logic [ADDR_W-1:0] base_q;
   burst_order_e      order_q;

   burst_load_sel #(.ADDR_W(ADDR_W)) u_sel (
      .cpu_stb  (cpu_strobe),
      .cpu_addr (cpu_addr),
      .ctl_stb  (ctl_strobe),
      .ctl_addr (ctl_addr),
      .load     (load),
      .sel_addr (sel_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q  <= '0;
         order_q <= ORD_XOR;
      end else if (load) begin
         base_q  <= sel_addr;
         order_q <= order_from_pin(seq_linear);
      end
   end

   burst_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .advance (advance),
      .beat    (beat_idx)
   );

   burst_order_map #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_map (
      .base  (base_q),
      .beat  (beat_idx),
      .order (order_q),
      .addr  (word_addr)
   );

   // R2, R4: the processor strobe always wins
   p_cpu_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_strobe |=> (word_addr == $past(cpu_addr)));

   // R3: the controller strobe loads when it is alone
   p_ctl_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_strobe && !cpu_strobe) |=> (word_addr == $past(ctl_addr)));

   // R10: the upper bits stay steady between loads
   p_upper_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(cpu_strobe || ctl_strobe) |=> $stable(word_addr[ADDR_W-1:BEAT_W]));

endmodule

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;

   localparam int AW = 12;
   localparam int BW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_strobe = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic          ctl_strobe = 1'b0;
   logic [AW-1:0] ctl_addr = '0;
   logic          advance = 1'b0;
   logic          seq_linear = 1'b0;
   logic [AW-1:0] word_addr;
   logic [BW-1:0] beat_idx;

   int total = 0;
   int bad   = 0;
   logic          done = 1'b0;

   // bench model of the block
   logic [AW-1:0] m_base = '0;
   logic [BW-1:0] m_beat = '0;
   logic          m_lin  = 1'b0;

   always #5 clk = ~clk;

   burst_addr_gen #(.ADDR_W(AW), .BEAT_W(BW)) i_burst_addr_gen (
      .clk(clk), .rst_n(rst_n),
      .cpu_strobe(cpu_strobe), .cpu_addr(cpu_addr),
      .ctl_strobe(ctl_strobe), .ctl_addr(ctl_addr),
      .advance(advance), .seq_linear(seq_linear),
      .word_addr(word_addr), .beat_idx(beat_idx)
   );

   function automatic logic [AW-1:0] exp_addr();
      logic [BW-1:0] lo;
      lo = m_lin ? BW'(m_base[BW-1:0] + m_beat) : (m_base[BW-1:0] ^ m_beat);
      return {m_base[AW-1:BW], lo};
   endfunction

   task automatic check(input string tag, input logic [AW-1:0] ea, input logic [BW-1:0] eb);
      total++;
      if (word_addr !== ea || beat_idx !== eb) begin
         bad++;
         $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
                  tag, word_addr, beat_idx, ea, eb);
      end
   endtask

   task automatic step(input string tag, input logic cs, input logic [AW-1:0] ca,
                       input logic ts, input logic [AW-1:0] ta,
                       input logic adv, input logic lin);
      @(negedge clk);
      cpu_strobe = cs; cpu_addr = ca; ctl_strobe = ts; ctl_addr = ta;
      advance = adv; seq_linear = lin;
      if (cs) begin
         m_base = ca; m_beat = '0; m_lin = lin;
      end else if (ts) begin
         m_base = ta; m_beat = '0; m_lin = lin;
      end else if (adv) begin
         m_beat = m_beat + 1'b1;
      end
      @(posedge clk);
      #1;
      check(tag, exp_addr(), m_beat);
   endtask

   initial begin
      #500000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: run did not finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #12;
      check("R1", '0, '0);
      @(negedge clk);
      rst_n = 1'b1;

      // R8 R9 R5: every start value, both orders, running past the wrap
      for (int o = 0; o < 2; o++) begin
         for (int s = 0; s < 8; s++) begin
            logic [AW-1:0] a;
            a = AW'(12'hA50 + s);
            step(o ? "R2 R8" : "R2 R9", 1'b1, a, 1'b0, '0, 1'b1, o[0]);
            for (int k = 0; k < 6; k++) begin
               step(o ? "R8 R5 R10" : "R9 R5 R10", 1'b0, '0, 1'b0, '0, 1'b1, o[0]);
            end
         end
      end

      // R3 controller load, then R6 holds
      step("R3", 1'b0, '0, 1'b1, 12'h3C7, 1'b0, 1'b1);
      step("R5", 1'b0, '0, 1'b0, '0, 1'b1, 1'b1);
      for (int k = 0; k < 3; k++) step("R6", 1'b0, '0, 1'b0, '0, 1'b0, 1'b0);

      // R4 both strobes: processor wins
      step("R4", 1'b1, 12'h111, 1'b1, 12'h222, 1'b0, 1'b0);
      step("R4", 1'b1, 12'h0F2, 1'b1, 12'hF0D, 1'b1, 1'b1);

      // R7 advance ignored on load cycles, mid-burst
      step("R5", 1'b0, '0, 1'b0, '0, 1'b1, 1'b0);
      step("R7", 1'b0, '0, 1'b1, 12'h5A3, 1'b1, 1'b0);
      step("R7", 1'b1, 12'h7E1, 1'b0, '0, 1'b1, 1'b1);

      // R11: order pin toggled during a burst has no effect
      step("R11", 1'b1, 12'h402, 1'b0, '0, 1'b0, 1'b1);
      for (int k = 0; k < 5; k++) step("R11", 1'b0, '0, 1'b0, '0, 1'b1, k[0]);
      step("R11", 1'b0, '0, 1'b1, 12'h803, 1'b0, 1'b0);
      for (int k = 0; k < 5; k++) step("R11", 1'b0, '0, 1'b0, '0, 1'b1, ~k[0]);

      // R12 back-to-back loads from alternating strobes
      for (int k = 0; k < 8; k++) begin
         step("R12", k[0], AW'(12'h100 * k + k), ~k[0], AW'(12'h0A0 + k), 1'b1, k[1]);
      end

      // R1 again: reset in the middle of a burst
      step("R5", 1'b0, '0, 1'b0, '0, 1'b1, 1'b0);
      @(negedge clk);
      rst_n = 1'b0;
      cpu_strobe = 1'b0; ctl_strobe = 1'b0; advance = 1'b0;
      #1;
      m_base = '0; m_beat = '0; m_lin = 1'b0;
      check("R1", '0, '0);
      @(negedge clk);
      rst_n = 1'b1;
      step("R9", 1'b0, '0, 1'b1, 12'h006, 1'b0, 1'b0);
      step("R9", 1'b0, '0, 1'b0, '0, 1'b1, 1'b1);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule